// File: doc/BRIEF.md
# Three-slot VLIW register file

This block holds the architectural registers of a datapath that issues three operations per very long instruction word. In every cycle each of the three slots presents an opcode and two source register indices, and the block returns the two matching source operands for that slot to the execute stage in the same cycle. Reads are combinational from the stored array. The writeback stage hands in three result words, each with its own destination index, under one shared write enable. Those results are stored on the next rising clock edge.

The block does no scoreboarding and no forwarding. When a slot reads a register in the same cycle that the register is written, the slot sees the value stored before that edge. A forwarding stage further down the pipe is expected to supply the newer data. When several slots write the same register in one cycle, the result is defined: the slot with the highest number wins. When a slot carries the no-operation opcode, both of its operands are forced to zero, whatever its indices hold.

The register count, the data width and the slot count are parameters. The index width is derived from the register count.

Top module: `vliw_regfile`

## Requirements
- R1: While `rst_n` is low, every register is cleared to zero. After reset is released, any register read by a slot whose opcode is not no-operation returns zero until it is written.
- R2: Each slot s reads its operands from bits [s*IW +: IW] of `src1_idx_i` and `src2_idx_i`. It returns them in bits [s*DW +: DW] of `src1_data_o` and `src2_data_o` in the same cycle. All six reads are independent and may name any register, including the same one.
- R3: When `wr_en_i` is high at a rising clock edge, slot s stores bits [s*DW +: DW] of `wr_data_i` into the register named by bits [s*IW +: IW] of `wr_idx_i`. The new value is readable from the cycle after that edge.
- R4: When `wr_en_i` is low at a rising clock edge, no register changes, whatever the write indices and data hold.
- R5: The no-operation opcode is the value 0 in a slot's 4-bit field, bits [s*4 +: 4] of `opcode_i`. Such a slot drives both of its operands to zero, and the other slots are unaffected. Any nonzero opcode reads normally.
- R6: A read of a register in the same cycle as a write to it returns the value stored before that clock edge.
- R7: When two or more slots write the same register in one cycle, the highest-numbered of those slots determines the stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes happen on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, clears all registers |
| opcode_i | input | NSLOT*4 | Per-slot opcode; 0 marks a no-operation slot |
| src1_idx_i | input | NSLOT*IW | Per-slot first-source register index |
| src2_idx_i | input | NSLOT*IW | Per-slot second-source register index |
| wr_en_i | input | 1 | Write enable shared by all three result ports |
| wr_idx_i | input | NSLOT*IW | Per-slot destination index of a result |
| wr_data_i | input | NSLOT*DW | Per-slot result word |
| src1_data_o | output | NSLOT*DW | Per-slot first source operand |
| src2_data_o | output | NSLOT*DW | Per-slot second source operand |

## Verification
The read path is first driven after reset with every index spread over the three slots. It is then driven with all six reads aimed at one register, with descending distinct indices, and with the first and second source of a slot differing. These patterns separate a crossed slot or operand lane from a correct one. Writes are issued while the same registers are being read, which tells old-value reads apart from write-through. A cycle with the enable low and junk data shows whether the enable is honoured. Collision patterns with all three slots, or two slots in each pairing, on one destination pin down the highest-slot-wins rule. No-operation opcodes are placed in one slot at a time and in all slots, which tells per-slot zeroing apart from zeroing that leaks across slots.

// File: rtl/vrf_pkg.sv
package vrf_pkg;
  localparam int unsigned OPC_W = 4;
  localparam logic [OPC_W-1:0] OPC_NOP = '0;
endpackage

// File: rtl/vrf_wr_merge.sv
// Collapses the per-slot result ports into one enable and one word per
// register. Later slots override earlier ones, so the top slot wins.
module vrf_wr_merge #(
  parameter int unsigned NREG  = 16,
  parameter int unsigned NSLOT = 3,
  parameter int unsigned DW    = 64,
  parameter int unsigned IW    = 4
) (
  input  logic                       wr_en_i,
  input  logic [NSLOT-1:0][IW-1:0]   idx_i,
  input  logic [NSLOT-1:0][DW-1:0]   data_i,
  output logic [NREG-1:0]            reg_we_o,
  output logic [NREG-1:0][DW-1:0]    reg_wd_o
);
  always_comb begin
    reg_we_o = '0;
    reg_wd_o = '0;
    for (int r = 0; r < NREG; r++) begin
      for (int s = 0; s < NSLOT; s++) begin
        if (wr_en_i && (idx_i[s] == IW'(r))) begin
          reg_we_o[r] = 1'b1;
          reg_wd_o[r] = data_i[s];
        end
      end
    end
  end
endmodule

// File: rtl/vrf_array.sv
// Register storage: one enabled flop row per register.
module vrf_array #(
  parameter int unsigned NREG = 16,
  parameter int unsigned DW   = 64
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NREG-1:0]         we_i,
  input  logic [NREG-1:0][DW-1:0] wd_i,
  output logic [NREG-1:0][DW-1:0] mem_o
);
  for (genvar r = 0; r < NREG; r++) begin : g_row
    logic [DW-1:0] row_d, row_q;

    always_comb begin
      row_d = row_q;
      if (we_i[r]) row_d = wd_i[r];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) row_q <= '0;
      else        row_q <= row_d;
    end

    assign mem_o[r] = row_q;

    // R3: an enabled write lands in the row at the next edge
    a_r3_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      we_i[r] |=> (mem_o[r] == $past(wd_i[r])));
    // R4: without an enable the row keeps its value
    a_r4_row_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !we_i[r] |=> $stable(mem_o[r]));
  end
endmodule

// File: rtl/vrf_rd_port.sv
// One combinational read port with no-operation zeroing.
module vrf_rd_port
  import vrf_pkg::*;
#(
  parameter int unsigned NREG = 16,
  parameter int unsigned DW   = 64,
  parameter int unsigned IW   = 4
) (
  input  logic [OPC_W-1:0]        opc_i,
  input  logic [IW-1:0]           idx_i,
  input  logic [NREG-1:0][DW-1:0] mem_i,
  output logic [DW-1:0]           data_o
);
  logic in_range;

  if (NREG < (1 << IW)) begin : g_partial
    assign in_range = ({1'b0, idx_i} < (IW+1)'(NREG));
  end else begin : g_full
    assign in_range = 1'b1;
  end

  always_comb begin
    data_o = '0;
    if ((opc_i != OPC_NOP) && in_range) data_o = mem_i[idx_i];
  end
endmodule

// File: rtl/vliw_regfile.sv
module vliw_regfile
  import vrf_pkg::*;
#(
  parameter int unsigned NREG  = 16,
  parameter int unsigned DW    = 64,
  parameter int unsigned NSLOT = 3,
  localparam int unsigned IW   = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NSLOT*OPC_W-1:0] opcode_i,
  input  logic [NSLOT*IW-1:0]    src1_idx_i,
  input  logic [NSLOT*IW-1:0]    src2_idx_i,
  input  logic                   wr_en_i,
  input  logic [NSLOT*IW-1:0]    wr_idx_i,
  input  logic [NSLOT*DW-1:0]    wr_data_i,
  output logic [NSLOT*DW-1:0]    src1_data_o,
  output logic [NSLOT*DW-1:0]    src2_data_o
);
  logic [NSLOT-1:0][OPC_W-1:0] opc_s;
  logic [NSLOT-1:0][IW-1:0]    rd1_idx_s, rd2_idx_s, wr_idx_s;
  logic [NSLOT-1:0][DW-1:0]    wr_data_s, rd1_data_s, rd2_data_s;
  logic [NREG-1:0]             reg_we;
  logic [NREG-1:0][DW-1:0]     reg_wd, mem_q;

  assign opc_s     = opcode_i;
  assign rd1_idx_s = src1_idx_i;
  assign rd2_idx_s = src2_idx_i;
  assign wr_idx_s  = wr_idx_i;
  assign wr_data_s = wr_data_i;

  vrf_wr_merge #(.NREG(NREG), .NSLOT(NSLOT), .DW(DW), .IW(IW)) u_merge (
    .wr_en_i (wr_en_i),
    .idx_i   (wr_idx_s),
    .data_i  (wr_data_s),
    .reg_we_o(reg_we),
    .reg_wd_o(reg_wd)
  );

  vrf_array #(.NREG(NREG), .DW(DW)) u_array (
    .clk  (clk),
    .rst_n(rst_n),
    .we_i (reg_we),
    .wd_i (reg_wd),
    .mem_o(mem_q)
  );

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    vrf_rd_port #(.NREG(NREG), .DW(DW), .IW(IW)) u_rd1 (
      .opc_i (opc_s[s]),
      .idx_i (rd1_idx_s[s]),
      .mem_i (mem_q),
      .data_o(rd1_data_s[s])
    );
    vrf_rd_port #(.NREG(NREG), .DW(DW), .IW(IW)) u_rd2 (
      .opc_i (opc_s[s]),
      .idx_i (rd2_idx_s[s]),
      .mem_i (mem_q),
      .data_o(rd2_data_s[s])
    );

    // R5: a no-operation slot drives zero on both operand outputs
    a_r5_nop_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (opcode_i[s*OPC_W +: OPC_W] == OPC_NOP) |->
        ((src1_data_o[s*DW +: DW] == '0) && (src2_data_o[s*DW +: DW] == '0)));
  end

  assign src1_data_o = rd1_data_s;
  assign src2_data_o = rd2_data_s;

  // R7: the top slot's result always ends up in its destination
  a_r7_top_slot_wins: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |=> (mem_q[$past(wr_idx_i[(NSLOT-1)*IW +: IW])] ==
                 $past(wr_data_i[(NSLOT-1)*DW +: DW])));
endmodule

// File: tb/vliw_regfile_tb_top.sv
`timescale 1ns/1ps
module vliw_regfile_tb_top;
  localparam int NREG = 16;
  localparam int DW   = 64;
  localparam int NS   = 3;
  localparam int IW   = 4;
  localparam int OW   = 4;

  logic              clk;
  logic              rst_n;
  logic [NS*OW-1:0]  opc;
  logic [NS*IW-1:0]  s1, s2, wi;
  logic              we;
  logic [NS*DW-1:0]  wd, r1, r2;

  typedef struct {
    string            req;
    logic [NS*DW-1:0] e1;
    logic [NS*DW-1:0] e2;
  } item_t;

  item_t         sbq[$];
  logic [DW-1:0] model [NREG];
  int            compared = 0;
  int            mismatched = 0;
  bit            done = 0;

  vliw_regfile #(.NREG(NREG), .DW(DW), .NSLOT(NS)) dut_i (
    .clk(clk), .rst_n(rst_n), .opcode_i(opc), .src1_idx_i(s1), .src2_idx_i(s2),
    .wr_en_i(we), .wr_idx_i(wi), .wr_data_i(wd),
    .src1_data_o(r1), .src2_data_o(r2)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [DW-1:0] val(int idx, int seed);
    return (64'h0101_0101_0101_0101 * 64'(seed)) ^ (64'h0123_4567_89AB_CDEF * 64'(idx + 1));
  endfunction

  function automatic logic [NS*IW-1:0] pk_idx(int a, int b, int c);
    return {IW'(c), IW'(b), IW'(a)};
  endfunction

  function automatic logic [NS*OW-1:0] pk_opc(int a, int b, int c);
    return {OW'(c), OW'(b), OW'(a)};
  endfunction

  // driver: applies one cycle of stimulus and queues the expected operands
  task automatic issue(string req, logic [NS*OW-1:0] o, logic [NS*IW-1:0] a,
                       logic [NS*IW-1:0] b, logic w, logic [NS*IW-1:0] wix,
                       logic [NS*DW-1:0] wdat);
    item_t it;
    @(negedge clk);
    opc = o; s1 = a; s2 = b; we = w; wi = wix; wd = wdat;
    it.req = req;
    for (int s = 0; s < NS; s++) begin
      if (o[s*OW +: OW] == '0) begin
        it.e1[s*DW +: DW] = '0;
        it.e2[s*DW +: DW] = '0;
      end else begin
        it.e1[s*DW +: DW] = model[a[s*IW +: IW]];
        it.e2[s*DW +: DW] = model[b[s*IW +: IW]];
      end
    end
    sbq.push_back(it);
    if (w) for (int s = 0; s < NS; s++) model[wix[s*IW +: IW]] = wdat[s*DW +: DW];
  endtask

  task automatic rd(string req, int a0, int a1, int a2, int b0, int b1, int b2);
    issue(req, pk_opc(1, 2, 3), pk_idx(a0, a1, a2), pk_idx(b0, b1, b2), 1'b0, '0, '0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    for (int r = 0; r < NREG; r++) model[r] = '0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // monitor: compares outputs shortly before the next rising edge
  initial begin
    forever begin
      @(negedge clk);
      #1.5;
      while (sbq.size() > 0) begin
        item_t it;
        it = sbq.pop_front();
        for (int s = 0; s < NS; s++) begin
          compared++;
          if (r1[s*DW +: DW] !== it.e1[s*DW +: DW]) begin
            mismatched++;
            $display("FAIL %s slot%0d src1: got %h expected %h", it.req, s,
                     r1[s*DW +: DW], it.e1[s*DW +: DW]);
          end
          compared++;
          if (r2[s*DW +: DW] !== it.e2[s*DW +: DW]) begin
            mismatched++;
            $display("FAIL %s slot%0d src2: got %h expected %h", it.req, s,
                     r2[s*DW +: DW], it.e2[s*DW +: DW]);
          end
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: got no completion, expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; opc = '0; s1 = '0; s2 = '0; we = 1'b0; wi = '0; wd = '0;
    for (int r = 0; r < NREG; r++) model[r] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: every register reads zero after reset
    for (int k = 0; k < 6; k++)
      rd("R1 reset", (3*k) % NREG, (3*k+1) % NREG, (3*k+2) % NREG,
                     (3*k+2) % NREG, (3*k) % NREG, (3*k+1) % NREG);

    // R3 and R6: fill every register while reading the same ones
    for (int k = 0; k < 6; k++) begin
      logic [NS*DW-1:0] d;
      for (int s = 0; s < NS; s++) d[s*DW +: DW] = val((3*k+s) % NREG, 1);
      issue("R6 old value", pk_opc(5, 6, 7),
            pk_idx((3*k) % NREG, (3*k+1) % NREG, (3*k+2) % NREG),
            pk_idx((3*k+2) % NREG, (3*k) % NREG, (3*k+1) % NREG),
            1'b1, pk_idx((3*k) % NREG, (3*k+1) % NREG, (3*k+2) % NREG), d);
    end
    for (int k = 0; k < 6; k++)
      rd("R3 written", (3*k) % NREG, (3*k+1) % NREG, (3*k+2) % NREG,
                       15 - k, 14 - k, 13 - k);

    // R2: independent read patterns
    rd("R2 all same", 9, 9, 9, 9, 9, 9);
    rd("R2 descending", 15, 14, 13, 12, 11, 10);
    rd("R2 mixed", 0, 15, 7, 8, 1, 14);

    // R4: disabled write with junk must change nothing
    issue("R4 no enable", pk_opc(1, 1, 1), pk_idx(0, 1, 2), pk_idx(3, 4, 5),
          1'b0, pk_idx(0, 1, 2), {3{64'hDEAD_BEEF_DEAD_BEEF}});
    rd("R4 readback", 0, 1, 2, 0, 1, 2);

    // R5: no-operation slots, one at a time and all at once
    issue("R5 nop slot0", pk_opc(0, 3, 9), pk_idx(4, 5, 6), pk_idx(7, 8, 9), 1'b0, '0, '0);
    issue("R5 nop slot1", pk_opc(2, 0, 15), pk_idx(4, 5, 6), pk_idx(7, 8, 9), 1'b0, '0, '0);
    issue("R5 nop slot2", pk_opc(8, 4, 0), pk_idx(4, 5, 6), pk_idx(7, 8, 9), 1'b0, '0, '0);
    issue("R5 nop all", pk_opc(0, 0, 0), pk_idx(4, 5, 6), pk_idx(7, 8, 9),
          1'b1, pk_idx(10, 11, 12), {val(12, 2), val(11, 2), val(10, 2)});
    rd("R5 readback", 10, 11, 12, 4, 5, 6);

    // R7: write collisions on one destination
    issue("R7 three-way", pk_opc(1, 1, 1), pk_idx(0, 0, 0), pk_idx(0, 0, 0),
          1'b1, pk_idx(5, 5, 5), {val(5, 7), val(5, 6), val(5, 5)});
    issue("R7 slots 0+1", pk_opc(1, 1, 1), pk_idx(5, 5, 5), pk_idx(5, 5, 5),
          1'b1, pk_idx(6, 6, 7), {val(7, 8), val(6, 9), val(6, 3)});
    issue("R7 slots 0+2", pk_opc(1, 1, 1), pk_idx(6, 7, 5), pk_idx(6, 7, 5),
          1'b1, pk_idx(8, 9, 8), {val(8, 4), val(9, 4), val(8, 11)});
    issue("R7 slots 1+2", pk_opc(1, 1, 1), pk_idx(8, 9, 6), pk_idx(7, 5, 8),
          1'b1, pk_idx(3, 2, 2), {val(2, 12), val(2, 13), val(3, 12)});
    rd("R7 readback", 5, 6, 7, 8, 9, 2);
    rd("R7 readback2", 3, 2, 8, 6, 5, 9);

    // R1: reset in mid-run clears everything again
    do_reset();
    for (int k = 0; k < 6; k++)
      rd("R1 second reset", (3*k) % NREG, (3*k+1) % NREG, (3*k+2) % NREG,
                            (3*k+1) % NREG, (3*k+2) % NREG, (3*k) % NREG);

    repeat (3) @(negedge clk);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule